// File: doc/BRIEF.md
# Row-Hazard-Aware Task Dispatcher

This block feeds a single processing element of a sparse-matrix by dense-matrix multiply engine. Every cycle up to four lanes can each offer one non-zero task. A task is a matrix value, a dense operand and the index of the accumulator row it contributes to. Each lane writes into a private queue. A round-robin arbiter takes at most one task per cycle from the queues that hold work.

A task is issued only if no earlier task for the same row is still inside the multi-cycle multiply-accumulate pipeline. A conflicting task is parked in a small stall buffer, one slot per pipeline stage. It is reissued as soon as its row has retired. Each issued task reads the row's partial sum from a local accumulator bank. The product is added and the pipeline writes the result back to the same row.

The pipeline is a fixed-latency model. It carries a row tag beside every in-flight sum, and the hazard check compares against those tags. A read port lets the surrounding logic fetch any accumulator row once the work is complete.

Top module: `rowtask_dispatch`

## Requirements
- R1: Each of the LANES input lanes has its own queue of QDEPTH entries. Lane l's fields sit at bits [l*W +: W] of `in_val`, `in_opnd` and `in_row`. A task is taken at a clock edge when `in_valid[l]` and `in_ready[l]` are both high. `in_ready[l]` is low exactly while lane l's queue is full, and no taken task is ever lost.
- R2: At most one task is issued per cycle. Among the non-empty queues, the arbiter picks the first lane at or after a rotating pointer. The pointer starts at lane 0 after reset and moves to the lane after the last one granted. A popped task without a conflict is issued in the same cycle it leaves its queue.
- R3: A task issued in cycle t (`issue_valid` high) appears on `wb_valid`/`wb_row` in cycle t+MAC_LAT.
- R4: Two issues of the same row are always more than MAC_LAT cycles apart.
- R5: A popped task whose row is in flight goes into a stall buffer of MAC_LAT entries. It is issued in the first cycle its row is clear. No queue is popped while the stall buffer is full.
- R6: When a stalled task is clear to go, it is issued ahead of any queue pop in that cycle.
- R7: The write-back value is the row's previous accumulator value plus value times operand, modulo 2^32. `rd_sum` shows accumulator row `rd_row` combinationally. All rows reset to 0.
- R8: `done` is high exactly when every queue, the stall buffer and the pipeline are empty.
- R9: After reset all `in_ready` bits are high, `issue_valid` and `wb_valid` are low and `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | LANES | Per-lane task offer |
| in_val | input | LANES*VAL_W | Per-lane sparse value |
| in_opnd | input | LANES*OPND_W | Per-lane dense operand |
| in_row | input | LANES*ROW_W | Per-lane destination row |
| in_ready | output | LANES | Per-lane queue has space |
| issue_valid | output | 1 | A task enters the pipeline this cycle |
| issue_row | output | ROW_W | Row of the issued task |
| wb_valid | output | 1 | Pipeline writes back this cycle |
| wb_row | output | ROW_W | Row being written back |
| wb_sum | output | ACC_W | Value being written back |
| rd_row | input | ROW_W | Accumulator row to read |
| rd_sum | output | ACC_W | Content of accumulator row `rd_row` |
| done | output | 1 | All queues, stall buffer and pipeline empty |

## Verification
The hardest case to reach from the ports is a stalled task that becomes clear while other queues still hold work, because that is the only cycle where stall-buffer priority decides anything. The bench reaches it in a fixed way. Two tasks for the same row go into one lane, and the other three lanes are kept full of distinct rows. Round-robin then brings the second task back exactly inside the hazard window, and the bench requires the reissue to come exactly MAC_LAT+1 cycles after the first issue. Queue back-pressure is reached by flooding one lane with a single row, so that hazards throttle the pops until the queue fills.

// File: rtl/rtd_pkg.sv
package rtd_pkg;
  parameter int VAL_W  = 16;
  parameter int OPND_W = 16;
  parameter int ROW_W  = 4;
  parameter int ACC_W  = 32;
  localparam int ROWS  = 1 << ROW_W;
  localparam int PROD_W = VAL_W + OPND_W;

  typedef struct packed {
    logic [VAL_W-1:0]  val;
    logic [OPND_W-1:0] opnd;
    logic [ROW_W-1:0]  row;
  } task_t;

  // product of one task added to a partial sum, wrapping at ACC_W bits
  function automatic logic [ACC_W-1:0] mac_step(input logic [ACC_W-1:0] acc,
                                                input task_t t);
    logic [PROD_W-1:0] p;
    p = {{OPND_W{1'b0}}, t.val} * {{VAL_W{1'b0}}, t.opnd};
    return acc + ACC_W'(p);
  endfunction
endpackage

// File: rtl/rtd_lane_fifo.sv
module rtd_lane_fifo
  import rtd_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  task_t push_data,
  output logic  ready,
  input  logic  pop,
  output logic  nonempty,
  output task_t head
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  task_t           mem [DEPTH];
  logic [PW-1:0]   wp, rp;
  logic [CW-1:0]   cnt;
  logic            do_push, do_pop, is_full;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign is_full  = (cnt == CW'(DEPTH));
  assign ready    = ~is_full;
  assign nonempty = (cnt != '0);
  assign head     = mem[rp];
  assign do_push  = push & ~is_full;
  assign do_pop   = pop & nonempty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  // R1: a full queue that is not popped stays closed to its lane
  a_r1_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && !pop) |=> !ready);
  // R2: the arbiter never pops an empty queue
  a_r2_no_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> nonempty);
endmodule

// File: rtl/rtd_rr_arb.sv
module rtd_rr_arb #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  input  logic                 advance,
  output logic [N-1:0]         grant,
  output logic [$clog2(N)-1:0] gnt_idx,
  output logic                 any
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr;

  always_comb begin
    grant   = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr) + k) % N;
      if (!any && req[idx]) begin
        any        = 1'b1;
        gnt_idx    = IW'(idx);
        grant[idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (advance && any)
      ptr <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
  end

  // R2: one grant at most, and only to a requester
  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r2_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
endmodule

// File: rtl/rtd_stall_buf.sv
module rtd_stall_buf
  import rtd_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  task_t            push_task,
  input  logic             take,
  input  logic [DEPTH-1:0] busy,
  output logic [ROW_W-1:0] ent_row [DEPTH],
  output logic             rel_valid,
  output task_t            rel_task,
  output logic             full,
  output logic             empty
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld;
  task_t            ent [DEPTH];
  logic [DEPTH-1:0] ready_m, free_m;
  logic [IW-1:0]    rel_idx, free_idx;

  for (genvar k = 0; k < DEPTH; k++) begin : g_rows
    assign ent_row[k] = ent[k].row;
  end

  always_comb begin
    ready_m  = vld & ~busy;
    free_m   = ~vld;
    rel_idx  = '0;
    free_idx = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (ready_m[k]) rel_idx  = IW'(k);
      if (free_m[k])  free_idx = IW'(k);
    end
  end

  assign rel_valid = |ready_m;
  assign rel_task  = ent[rel_idx];
  assign full      = &vld;
  assign empty     = ~|vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else begin
      if (take && rel_valid) vld[rel_idx]  <= 1'b0;
      if (push && !full)     vld[free_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) ent[free_idx] <= push_task;
  end

  // R5: the dispatcher never parks a task into a full buffer
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R5: a released slot is empty on the next cycle unless refilled
  a_r5_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take && rel_valid && !push) |=> $countones(vld) == $countones($past(vld)) - 1);
endmodule

// File: rtl/rtd_mac_pipe.sv
module rtd_mac_pipe
  import rtd_pkg::*;
#(
  parameter int LAT = 4,
  parameter int NQ  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [ROW_W-1:0] iss_row,
  input  logic [ACC_W-1:0] iss_sum,
  input  logic [ROW_W-1:0] pop_row,
  output logic             pop_busy,
  input  logic [ROW_W-1:0] q_row [NQ],
  output logic [NQ-1:0]    q_busy,
  output logic             wb_valid,
  output logic [ROW_W-1:0] wb_row,
  output logic [ACC_W-1:0] wb_sum,
  output logic             active
);
  logic [LAT-1:0]   vld;
  logic [ROW_W-1:0] row [LAT];
  logic [ACC_W-1:0] sum [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else begin
      vld[0] <= iss_valid;
      for (int s = 1; s < LAT; s++) vld[s] <= vld[s-1];
    end
  end

  always_ff @(posedge clk) begin
    row[0] <= iss_row;
    sum[0] <= iss_sum;
    for (int s = 1; s < LAT; s++) begin
      row[s] <= row[s-1];
      sum[s] <= sum[s-1];
    end
  end

  // row-tag comparison against every occupied stage
  always_comb begin
    pop_busy = 1'b0;
    q_busy   = '0;
    for (int s = 0; s < LAT; s++) begin
      if (vld[s] && row[s] == pop_row) pop_busy = 1'b1;
      for (int k = 0; k < NQ; k++)
        if (vld[s] && row[s] == q_row[k]) q_busy[k] = 1'b1;
    end
  end

  assign wb_valid = vld[LAT-1];
  assign wb_row   = row[LAT-1];
  assign wb_sum   = sum[LAT-1];
  assign active   = |vld;

  // R4: no two occupied stages ever carry the same row
  for (genvar i = 0; i < LAT; i++) begin : g_ci
    for (genvar j = i + 1; j < LAT; j++) begin : g_cj
      a_r4_unique_rows: assert property (@(posedge clk) disable iff (!rst_n)
        !(vld[i] && vld[j] && row[i] == row[j]));
    end
  end
endmodule

// File: rtl/rowtask_dispatch.sv
module rowtask_dispatch
  import rtd_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int QDEPTH  = 4,
  parameter int MAC_LAT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        in_valid,
  input  logic [LANES*VAL_W-1:0]  in_val,
  input  logic [LANES*OPND_W-1:0] in_opnd,
  input  logic [LANES*ROW_W-1:0]  in_row,
  output logic [LANES-1:0]        in_ready,
  output logic                    issue_valid,
  output logic [ROW_W-1:0]        issue_row,
  output logic                    wb_valid,
  output logic [ROW_W-1:0]        wb_row,
  output logic [ACC_W-1:0]        wb_sum,
  input  logic [ROW_W-1:0]        rd_row,
  output logic [ACC_W-1:0]        rd_sum,
  output logic                    done
);
  localparam int LW = $clog2(LANES);

  task_t            q_head [LANES];
  logic [LANES-1:0] q_nonempty, q_pop, grant;
  logic [LW-1:0]    gnt_idx;
  logic             any_req;

  task_t            pop_task, iss_task, stl_task;
  logic             pop_en, pop_hz, stl_rel, stl_full, stl_empty, stl_push;
  logic [ROW_W-1:0] stl_rows [MAC_LAT];
  logic [MAC_LAT-1:0] stl_busy;
  logic             pipe_active;
  logic [ACC_W-1:0] iss_sum;
  logic [ACC_W-1:0] acc [ROWS];

  // one queue per lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    task_t lane_task;
    assign lane_task.val  = in_val[l*VAL_W +: VAL_W];
    assign lane_task.opnd = in_opnd[l*OPND_W +: OPND_W];
    assign lane_task.row  = in_row[l*ROW_W +: ROW_W];
    assign q_pop[l]       = pop_en & grant[l];

    rtd_lane_fifo #(.DEPTH(QDEPTH)) u_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (in_valid[l]),
      .push_data(lane_task),
      .ready    (in_ready[l]),
      .pop      (q_pop[l]),
      .nonempty (q_nonempty[l]),
      .head     (q_head[l])
    );
  end

  rtd_rr_arb #(.N(LANES)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (q_nonempty),
    .advance(pop_en),
    .grant  (grant),
    .gnt_idx(gnt_idx),
    .any    (any_req)
  );

  rtd_stall_buf #(.DEPTH(MAC_LAT)) u_stall (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (stl_push),
    .push_task(pop_task),
    .take     (stl_rel),
    .busy     (stl_busy),
    .ent_row  (stl_rows),
    .rel_valid(stl_rel),
    .rel_task (stl_task),
    .full     (stl_full),
    .empty    (stl_empty)
  );

  rtd_mac_pipe #(.LAT(MAC_LAT), .NQ(MAC_LAT)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .iss_valid(issue_valid),
    .iss_row  (iss_task.row),
    .iss_sum  (iss_sum),
    .pop_row  (pop_task.row),
    .pop_busy (pop_hz),
    .q_row    (stl_rows),
    .q_busy   (stl_busy),
    .wb_valid (wb_valid),
    .wb_row   (wb_row),
    .wb_sum   (wb_sum),
    .active   (pipe_active)
  );

  // issue policy: cleared stalled work first, then one queue pop if there is room to park it
  always_comb begin
    pop_task    = q_head[gnt_idx];
    pop_en      = any_req & ~stl_rel & ~stl_full;
    stl_push    = pop_en & pop_hz;
    issue_valid = stl_rel | (pop_en & ~pop_hz);
    iss_task    = stl_rel ? stl_task : pop_task;
    iss_sum     = mac_step(acc[iss_task.row], iss_task);
  end

  assign issue_row = iss_task.row;
  assign rd_sum    = acc[rd_row];
  assign done      = ~(|q_nonempty) & stl_empty & ~pipe_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) acc[r] <= '0;
    end else if (wb_valid) begin
      acc[wb_row] <= wb_sum;
    end
  end

  // R6: a releasing stall entry blocks every queue pop in that cycle
  a_r6_stall_first: assert property (@(posedge clk) disable iff (!rst_n)
    stl_rel |-> (q_pop == '0));
  // R8: an idle block issues nothing and writes nothing
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!issue_valid && !wb_valid));
  // R2: at most one queue is popped per cycle
  a_r2_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_pop));
endmodule

// File: tb/rowtask_dispatch_tb.sv
module rowtask_dispatch_tb;
  import rtd_pkg::*;

  localparam int NL  = 4;
  localparam int QD  = 4;
  localparam int LAT = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NL-1:0]        in_valid = '0;
  logic [NL*VAL_W-1:0]  in_val = '0;
  logic [NL*OPND_W-1:0] in_opnd = '0;
  logic [NL*ROW_W-1:0]  in_row = '0;
  logic [NL-1:0]        in_ready;
  logic                 issue_valid, wb_valid, done;
  logic [ROW_W-1:0]     issue_row, wb_row;
  logic [ACC_W-1:0]     wb_sum, rd_sum;
  logic [ROW_W-1:0]     rd_row = '0;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  logic [ACC_W-1:0] exp_acc [ROWS];
  int last_iss [ROWS];
  int r7_cyc [2];
  int r7_n = 0;
  int o_row [NL];
  int o_val [NL];
  int o_opnd [NL];

  rowtask_dispatch #(.LANES(NL), .QDEPTH(QD), .MAC_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_val(in_val),
    .in_opnd(in_opnd), .in_row(in_row), .in_ready(in_ready),
    .issue_valid(issue_valid), .issue_row(issue_row),
    .wb_valid(wb_valid), .wb_row(wb_row), .wb_sum(wb_sum),
    .rd_row(rd_row), .rd_sum(rd_sum), .done(done)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // running scoreboard: write-back latency (R3) and same-row spacing (R4)
  always @(negedge clk) begin
    if (rst_n) begin
      if (wb_valid) chk("R3", "writeback latency", 64'(cyc - last_iss[wb_row]), 64'(LAT));
      if (issue_valid) begin
        if (last_iss[issue_row] > -1000)
          chk("R4", "same-row gap over latency", 64'(cyc - last_iss[issue_row] > LAT), 64'd1);
        last_iss[issue_row] = cyc;
        if (issue_row == 4'd7 && r7_n < 2) begin
          r7_cyc[r7_n] = cyc;
          r7_n++;
        end
      end
    end
  end

  task automatic offer(input logic [NL-1:0] m, output logic [NL-1:0] took);
    @(negedge clk);
    for (int l = 0; l < NL; l++) begin
      in_valid[l] = m[l];
      in_row[l*ROW_W +: ROW_W]    = ROW_W'(o_row[l]);
      in_val[l*VAL_W +: VAL_W]    = VAL_W'(o_val[l]);
      in_opnd[l*OPND_W +: OPND_W] = OPND_W'(o_opnd[l]);
    end
    took = m & in_ready;
    for (int l = 0; l < NL; l++)
      if (took[l])
        exp_acc[o_row[l]] = exp_acc[o_row[l]] + (32'(o_val[l]) * 32'(o_opnd[l]));
    @(posedge clk);
    #1 in_valid = '0;
  endtask

  task automatic wait_done(input string req);
    int k;
    for (k = 0; k < 600; k++) begin
      @(negedge clk);
      if (done) break;
    end
    chk(req, "drained to done", 64'(done), 64'd1);
  endtask

  task automatic check_rows(input string req);
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      rd_row = ROW_W'(r);
      #1 chk(req, "accumulator row", 64'(rd_sum), 64'(exp_acc[r]));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9", "ready after reset", 64'(in_ready), 64'hF);
    chk("R9", "no issue after reset", 64'(issue_valid), 64'd0);
    chk("R9", "no writeback after reset", 64'(wb_valid), 64'd0);
    chk("R8", "done after reset", 64'(done), 64'd1);
    rd_row = 4'd0;
    #1 chk("R7", "row cleared by reset", 64'(rd_sum), 64'd0);
  endtask

  task automatic t_single();
    logic [NL-1:0] took;
    int t0;
    o_row[2] = 5; o_val[2] = 3; o_opnd[2] = 4;
    offer(4'b0100, took);
    @(negedge clk);
    t0 = cyc;
    chk("R2", "lone task issued next cycle", 64'(issue_valid), 64'd1);
    chk("R2", "issued row", 64'(issue_row), 64'd5);
    chk("R8", "busy while working", 64'(done), 64'd0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (wb_valid) break;
    end
    chk("R3", "single latency", 64'(cyc - t0), 64'(LAT));
    chk("R7", "writeback row", 64'(wb_row), 64'd5);
    chk("R7", "writeback value", 64'(wb_sum), 64'd12);
    @(negedge clk);
    chk("R8", "done right after writeback", 64'(done), 64'd1);
    check_rows("R7");
  endtask

  task automatic t_round_robin();
    logic [NL-1:0] took;
    int exp_rows [NL];
    for (int l = 0; l < NL; l++) begin
      o_row[l] = l; o_val[l] = 10 + l; o_opnd[l] = 2 + l;
    end
    offer(4'b1111, took);
    // pointer sits at lane 3 after the lone grant to lane 2
    exp_rows = '{3, 0, 1, 2};
    for (int k = 0; k < NL; k++) begin
      @(negedge clk);
      chk("R2", "back-to-back issue", 64'(issue_valid), 64'd1);
      chk("R2", "round-robin order", 64'(issue_row), 64'(exp_rows[k]));
    end
    wait_done("R8");
    check_rows("R7");
  endtask

  task automatic t_hazard();
    logic [NL-1:0] took;
    o_row[0] = 9; o_val[0] = 7;  o_opnd[0] = 3;
    o_row[1] = 9; o_val[1] = 11; o_opnd[1] = 5;
    offer(4'b0011, took);
    @(negedge clk);
    chk("R4", "first row-9 issue", 64'(issue_valid && issue_row == 4'd9), 64'd1);
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      chk("R4", "hazard holds issue", 64'(issue_valid), 64'd0);
    end
    @(negedge clk);
    chk("R5", "stalled task reissued when clear",
        64'(issue_valid && issue_row == 4'd9), 64'd1);
    wait_done("R5");
    check_rows("R5");
  endtask

  task automatic t_priority();
    logic [NL-1:0] took;
    int rows_l [NL][4];
    rows_l[1] = '{0, 1, 2, 3};
    rows_l[2] = '{4, 5, 6, 8};
    rows_l[3] = '{10, 11, 12, 13};
    r7_n = 0;
    for (int k = 0; k < 4; k++) begin
      o_row[0] = 7; o_val[0] = 20 + k; o_opnd[0] = 1;
      for (int l = 1; l < NL; l++) begin
        o_row[l] = rows_l[l][k]; o_val[l] = 30 + k + l; o_opnd[l] = 3;
      end
      offer((k < 2) ? 4'b1111 : 4'b1110, took);
      chk("R1", "no back-pressure on light load", 64'(took), 64'((k < 2) ? 4'hF : 4'hE));
    end
    wait_done("R6");
    chk("R6", "two row-7 issues seen", 64'(r7_n), 64'd2);
    chk("R6", "cleared stall wins over pops", 64'(r7_cyc[1] - r7_cyc[0]), 64'(LAT + 1));
    check_rows("R6");
  endtask

  task automatic t_backpressure();
    logic [NL-1:0] took;
    int taken = 0;
    logic saw_low = 1'b0;
    for (int k = 0; k < 24; k++) begin
      o_row[0] = 2; o_val[0] = k + 1; o_opnd[0] = 1;
      offer(4'b0001, took);
      if (took[0]) taken++;
      else saw_low = 1'b1;
    end
    chk("R1", "lane 0 queue filled and closed", 64'(saw_low), 64'd1);
    chk("R1", "other lanes stay open", 64'(in_ready[3:1]), 64'h7);
    wait_done("R5");
    check_rows("R1");
  endtask

  task automatic t_mixed();
    logic [NL-1:0] took;
    for (int k = 0; k < 12; k++) begin
      for (int l = 0; l < NL; l++) begin
        o_row[l] = (k * 5 + l * 3) % ROWS;
        o_val[l] = 100 * k + l + 1;
        o_opnd[l] = 65535 - k;
      end
      offer(4'b1111, took);
    end
    wait_done("R8");
    check_rows("R7");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int r = 0; r < ROWS; r++) begin
      exp_acc[r] = '0;
      last_iss[r] = -100000;
    end
    for (int l = 0; l < NL; l++) begin
      o_row[l] = 0; o_val[l] = 0; o_opnd[l] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_round_robin();
    t_hazard();
    t_priority();
    t_backpressure();
    t_mixed();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule